// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block is the command front end of a parallel NOR flash model. The host bus presents one-cycle write strobes, each with an address and a data byte. The decoder interprets these strobes as one-cycle, two-cycle, address-plus-data and variable-length buffered command sequences. It keeps the current read mode, the status error bits and the status-pin configuration. It turns each completed sequence into a one-cycle request, carrying an address and a data byte, to a downstream write/erase engine.

The engine is a separate block. It reports `eng_busy` while an operation runs and pulses `eng_done` when the operation ends. The decoder uses the busy flag to restrict which commands it accepts during an operation. It also tracks suspend and resume of the running operation. Buffered writes are not stored here: each buffered word goes downstream as its own load request, and a commit request follows on confirm.

Top module: `fcmd_decoder`

## Requirements
- R1: After reset, `read_mode` is array (0), all three error bits are 0, `pin_mode` is 0, `suspended` is 0 and no request output is high.
- R2: In the idle state, a single write of FFh, 90h, 98h or 70h sets `read_mode` to array (0), identifier (1), query (2) or status (3) respectively.
- R3: A single write of 50h in the idle state clears `err_erase`, `err_prog` and `err_seq`.
- R4: A write of 20h followed by D0h issues `op_req` with `op_kind` 0 (block erase) and the confirm cycle's address. A write of 30h followed by D0h issues `op_kind` 1 (chip erase). Every request sets `read_mode` to status.
- R5: A write of 40h or 10h, followed by any write, issues `op_kind` 2 (program) with that second write's address and data.
- R6: After E8h at a start address, the next byte is a count C = N-1, and C must be below BUF_WORDS. Each of the next N writes issues `op_kind` 3 (buffer load) with its address and data. A following D0h issues `op_kind` 4 (commit) with the start address and `op_data` = C. If C is BUF_WORDS or more, the sequence aborts and sets `err_prog` and `err_seq`.
- R7: A write of 60h followed by 01h issues `op_kind` 5 (lock set) with the second cycle's address. A write of 60h followed by D0h issues `op_kind` 6 (clear all locks).
- R8: A write of B8h followed by 00h..03h sets `pin_mode` to that value. The values mean: 0 level ready/busy, 1 pulse on erase, 2 pulse on write, 3 pulse on both.
- R9: When a second cycle does not carry the expected code, the decoder sets error bits, switches `read_mode` to status, issues no request and returns to idle. A bad erase confirm sets `err_erase` and `err_seq`. A bad buffer confirm sets `err_prog` and `err_seq`. A bad lock confirm sets all three bits. A bad pin-mode value sets `err_seq` only.
- R10: A data byte outside the command set, written in the idle state, changes no output.
- R11: While `eng_busy` is high in the idle state, only 70h, B0h and B8h are accepted; every other code is ignored.
- R12: B0h while busy and not suspended pulses `suspend_req` and sets `suspended`. D0h in idle while suspended pulses `resume_req` and clears `suspended`. Both commands set `read_mode` to status.
- R13: `eng_done` clears `suspended`. If `eng_done` arrives in the same cycle as a suspend or resume command, `eng_done` wins and no suspend or resume pulse is produced; `read_mode` still becomes status.
- R14: At most one of `op_req`, `suspend_req` and `resume_req` is high in any cycle. Each reflects the write of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data / command code |
| eng_busy | input | 1 | Engine operation in progress |
| eng_done | input | 1 | Engine operation finished (pulse) |
| read_mode | output | 2 | 0 array, 1 identifier, 2 query, 3 status |
| op_req | output | 1 | One-cycle request to engine |
| op_kind | output | 3 | Request type (see R4 to R7) |
| op_addr | output | AW | Request address |
| op_data | output | 8 | Request data |
| suspend_req | output | 1 | Suspend pulse |
| resume_req | output | 1 | Resume pulse |
| suspended | output | 1 | Operation is suspended |
| pin_mode | output | 2 | Status-pin configuration |
| err_erase | output | 1 | Erase error bit |
| err_prog | output | 1 | Program error bit |
| err_seq | output | 1 | Command sequence error bit |

## Verification
The engine's completion and a suspend or resume command can land on the same clock edge. In that case the decoder must drop the suspend or resume pulse while still clearing `suspended` and showing status. The bench drives `eng_done` in the very cycle that carries D0h to a suspended decoder. It then checks that `resume_req` stays low, `suspended` is 0 and `read_mode` is 3. A second case pulses `eng_done` alone to show that it clears the flag. A further check confirms that a request, a suspend and a resume never appear together.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_IDENT  = 2'd1,
    RD_QUERY  = 2'd2,
    RD_STATUS = 2'd3
  } rd_mode_e;

  typedef enum logic [2:0] {
    OP_BLK_ERASE  = 3'd0,
    OP_CHIP_ERASE = 3'd1,
    OP_PROG       = 3'd2,
    OP_BUF_LOAD   = 3'd3,
    OP_BUF_COMMIT = 3'd4,
    OP_LOCK_SET   = 3'd5,
    OP_LOCK_CLR   = 3'd6
  } op_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_BLK_CF, S_CHIP_CF, S_PROG_WR, S_BUF_CNT,
    S_BUF_LD, S_BUF_CF, S_LOCK_CF, S_PIN_CF
  } seq_state_e;

  localparam logic [7:0] C_ARRAY     = 8'hFF;
  localparam logic [7:0] C_IDENT     = 8'h90;
  localparam logic [7:0] C_QUERY     = 8'h98;
  localparam logic [7:0] C_STATUS    = 8'h70;
  localparam logic [7:0] C_CLR_ERR   = 8'h50;
  localparam logic [7:0] C_BLK_ERASE = 8'h20;
  localparam logic [7:0] C_CHIP_ERS  = 8'h30;
  localparam logic [7:0] C_PROG_A    = 8'h40;
  localparam logic [7:0] C_PROG_B    = 8'h10;
  localparam logic [7:0] C_BUF_PROG  = 8'hE8;
  localparam logic [7:0] C_SUSPEND   = 8'hB0;
  localparam logic [7:0] C_CONFIRM   = 8'hD0;
  localparam logic [7:0] C_LOCK      = 8'h60;
  localparam logic [7:0] C_LOCK_SET  = 8'h01;
  localparam logic [7:0] C_PIN_CFG   = 8'hB8;

  typedef struct packed {
    logic     mode_vld;
    rd_mode_e mode;
    logic     set_erase;
    logic     set_prog;
    logic     set_seq;
    logic     clr_err;
    logic     pin_vld;
    logic [1:0] pin;
  } stat_upd_t;

endpackage

// File: rtl/fcmd_rst_sync.sv
module fcmd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
#(
  parameter int AW        = 22,
  parameter int BUF_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          eng_busy,
  input  logic          suspended,
  output logic          op_req,
  output op_kind_e      op_kind,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output stat_upd_t     upd,
  output logic          susp_go,
  output logic          resume_go
);
  localparam int CW = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;

  seq_state_e    state_q, state_d;
  logic [CW-1:0] remain_q, remain_d;
  logic [7:0]    cnt_q, cnt_d;
  logic [AW-1:0] base_q, base_d;
  logic          req_q, req_d;
  op_kind_e      kind_q, kind_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    data_q, data_d;

  logic          iss;
  op_kind_e      iss_kind;
  logic [AW-1:0] iss_addr;
  logic [7:0]    iss_data;
  logic          accept;

  assign accept = !eng_busy || (wr_data == C_STATUS) ||
                  (wr_data == C_SUSPEND) || (wr_data == C_PIN_CFG);

  always_comb begin
    state_d   = state_q;
    remain_d  = remain_q;
    cnt_d     = cnt_q;
    base_d    = base_q;
    upd       = '0;
    upd.mode  = RD_STATUS;
    susp_go   = 1'b0;
    resume_go = 1'b0;
    iss       = 1'b0;
    iss_kind  = OP_PROG;
    iss_addr  = wr_addr;
    iss_data  = wr_data;
    if (wr_en) begin
      case (state_q)
        S_IDLE: if (accept) begin
          case (wr_data)
            C_ARRAY:     begin upd.mode_vld = 1'b1; upd.mode = RD_ARRAY; end
            C_IDENT:     begin upd.mode_vld = 1'b1; upd.mode = RD_IDENT; end
            C_QUERY:     begin upd.mode_vld = 1'b1; upd.mode = RD_QUERY; end
            C_STATUS:    upd.mode_vld = 1'b1;
            C_CLR_ERR:   upd.clr_err = 1'b1;
            C_BLK_ERASE: state_d = S_BLK_CF;
            C_CHIP_ERS:  state_d = S_CHIP_CF;
            C_PROG_A,
            C_PROG_B:    state_d = S_PROG_WR;
            C_BUF_PROG:  begin state_d = S_BUF_CNT; base_d = wr_addr; end
            C_LOCK:      state_d = S_LOCK_CF;
            C_PIN_CFG:   state_d = S_PIN_CF;
            C_SUSPEND:   if (eng_busy && !suspended) begin
                           susp_go = 1'b1; upd.mode_vld = 1'b1;
                         end
            C_CONFIRM:   if (suspended) begin
                           resume_go = 1'b1; upd.mode_vld = 1'b1;
                         end
            default: ;
          endcase
        end
        S_BLK_CF, S_CHIP_CF: begin
          state_d = S_IDLE;
          if (wr_data == C_CONFIRM) begin
            iss      = 1'b1;
            iss_kind = (state_q == S_BLK_CF) ? OP_BLK_ERASE : OP_CHIP_ERASE;
          end else begin
            upd.set_erase = 1'b1; upd.set_seq = 1'b1; upd.mode_vld = 1'b1;
          end
        end
        S_PROG_WR: begin
          state_d = S_IDLE; iss = 1'b1; iss_kind = OP_PROG;
        end
        S_BUF_CNT: begin
          if ({1'b0, wr_data} < 9'(BUF_WORDS)) begin
            state_d  = S_BUF_LD;
            cnt_d    = wr_data;
            remain_d = wr_data[CW-1:0];
          end else begin
            state_d = S_IDLE;
            upd.set_prog = 1'b1; upd.set_seq = 1'b1; upd.mode_vld = 1'b1;
          end
        end
        S_BUF_LD: begin
          iss = 1'b1; iss_kind = OP_BUF_LOAD;
          if (remain_q == '0) state_d = S_BUF_CF;
          else                remain_d = remain_q - 1'b1;
        end
        S_BUF_CF: begin
          state_d = S_IDLE;
          if (wr_data == C_CONFIRM) begin
            iss = 1'b1; iss_kind = OP_BUF_COMMIT;
            iss_addr = base_q; iss_data = cnt_q;
          end else begin
            upd.set_prog = 1'b1; upd.set_seq = 1'b1; upd.mode_vld = 1'b1;
          end
        end
        S_LOCK_CF: begin
          state_d = S_IDLE;
          if (wr_data == C_LOCK_SET) begin
            iss = 1'b1; iss_kind = OP_LOCK_SET;
          end else if (wr_data == C_CONFIRM) begin
            iss = 1'b1; iss_kind = OP_LOCK_CLR;
          end else begin
            upd.set_erase = 1'b1; upd.set_prog = 1'b1;
            upd.set_seq = 1'b1; upd.mode_vld = 1'b1;
          end
        end
        S_PIN_CF: begin
          state_d = S_IDLE;
          if (wr_data < 8'd4) begin
            upd.pin_vld = 1'b1; upd.pin = wr_data[1:0];
          end else begin
            upd.set_seq = 1'b1; upd.mode_vld = 1'b1;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
    if (iss) upd.mode_vld = 1'b1;
  end

  always_comb begin
    req_d  = iss;
    kind_d = iss ? iss_kind : kind_q;
    addr_d = iss ? iss_addr : addr_q;
    data_d = iss ? iss_data : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      remain_q <= '0;
      cnt_q    <= '0;
      base_q   <= '0;
      req_q    <= 1'b0;
      kind_q   <= OP_BLK_ERASE;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
      cnt_q    <= cnt_d;
      base_q   <= base_d;
      req_q    <= req_d;
      kind_q   <= kind_d;
      addr_q   <= addr_d;
      data_q   <= data_d;
    end
  end

  assign op_req  = req_q;
  assign op_kind = kind_q;
  assign op_addr = addr_q;
  assign op_data = data_q;
endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
  import fcmd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  stat_upd_t upd,
  output rd_mode_e  read_mode,
  output logic [1:0] pin_mode,
  output logic      err_erase,
  output logic      err_prog,
  output logic      err_seq
);
  rd_mode_e   mode_q, mode_d;
  logic [1:0] pin_q, pin_d;
  logic [2:0] err_q, err_d;

  always_comb begin
    mode_d = upd.mode_vld ? upd.mode : mode_q;
    pin_d  = upd.pin_vld ? upd.pin : pin_q;
    err_d  = upd.clr_err ? 3'b000 : err_q;
    err_d  = err_d | {upd.set_seq, upd.set_prog, upd.set_erase};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RD_ARRAY;
      pin_q  <= 2'd0;
      err_q  <= 3'b000;
    end else begin
      mode_q <= mode_d;
      pin_q  <= pin_d;
      err_q  <= err_d;
    end
  end

  assign read_mode = mode_q;
  assign pin_mode  = pin_q;
  assign err_erase = err_q[0];
  assign err_prog  = err_q[1];
  assign err_seq   = err_q[2];
endmodule

// File: rtl/fcmd_susp.sv
module fcmd_susp (
  input  logic clk,
  input  logic rst_n,
  input  logic susp_go,
  input  logic resume_go,
  input  logic eng_done,
  output logic suspended,
  output logic suspend_req,
  output logic resume_req
);
  logic susp_q, susp_d;
  logic sreq_q, sreq_d;
  logic rreq_q, rreq_d;

  always_comb begin
    susp_d = susp_q;
    if (eng_done)       susp_d = 1'b0;
    else if (susp_go)   susp_d = 1'b1;
    else if (resume_go) susp_d = 1'b0;
    sreq_d = susp_go && !eng_done;
    rreq_d = resume_go && !eng_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp_q <= 1'b0;
      sreq_q <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      susp_q <= susp_d;
      sreq_q <= sreq_d;
      rreq_q <= rreq_d;
    end
  end

  assign suspended   = susp_q;
  assign suspend_req = sreq_q;
  assign resume_req  = rreq_q;
endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
  import fcmd_pkg::*;
#(
  parameter int AW        = 22,
  parameter int BUF_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          eng_busy,
  input  logic          eng_done,
  output logic [1:0]    read_mode,
  output logic          op_req,
  output logic [2:0]    op_kind,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          suspend_req,
  output logic          resume_req,
  output logic          suspended,
  output logic [1:0]    pin_mode,
  output logic          err_erase,
  output logic          err_prog,
  output logic          err_seq
);
  logic      rst_n_s;
  stat_upd_t upd;
  logic      susp_go, resume_go;
  op_kind_e  kind_e;
  rd_mode_e  mode_e;

  fcmd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  fcmd_seq #(.AW(AW), .BUF_WORDS(BUF_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .eng_busy(eng_busy), .suspended(suspended),
    .op_req(op_req), .op_kind(kind_e), .op_addr(op_addr), .op_data(op_data),
    .upd(upd), .susp_go(susp_go), .resume_go(resume_go)
  );

  fcmd_status u_stat (
    .clk(clk), .rst_n(rst_n_s), .upd(upd), .read_mode(mode_e),
    .pin_mode(pin_mode), .err_erase(err_erase), .err_prog(err_prog),
    .err_seq(err_seq)
  );

  fcmd_susp u_susp (
    .clk(clk), .rst_n(rst_n_s), .susp_go(susp_go), .resume_go(resume_go),
    .eng_done(eng_done), .suspended(suspended),
    .suspend_req(suspend_req), .resume_req(resume_req)
  );

  assign op_kind   = kind_e;
  assign read_mode = mode_e;
endmodule

// File: rtl/fcmd_decoder_chk.sv
module fcmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       op_req,
  input logic [1:0] read_mode,
  input logic       suspend_req,
  input logic       resume_req,
  input logic       suspended,
  input logic [1:0] pin_mode,
  input logic       err_seq
);
  // R14
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_req, suspend_req, resume_req}));

  // R14
  req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req || suspend_req || resume_req) |-> $past(wr_en));

  // R4
  req_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_req |-> read_mode == 2'd3);

  // R12
  susp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> suspended && !$past(suspended));

  // R12
  resume_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> !suspended && $past(suspended));

  // R9
  seq_err_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_seq) |-> read_mode == 2'd3);

  // R8
  pin_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_mode) |-> $past(wr_en) && ($past(wr_data) < 8'd4));
endmodule

bind fcmd_decoder fcmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .op_req(op_req), .read_mode(read_mode), .suspend_req(suspend_req),
  .resume_req(resume_req), .suspended(suspended), .pin_mode(pin_mode),
  .err_seq(err_seq)
);

// File: tb/fcmd_decoder_test.sv
module fcmd_decoder_test;
  localparam int AW = 22;
  localparam int BW = 16;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          eng_busy, eng_done;
  logic [1:0]    read_mode, pin_mode;
  logic          op_req, suspend_req, resume_req, suspended;
  logic [2:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data;
  logic          err_erase, err_prog, err_seq;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 0;

  fcmd_decoder #(.AW(AW), .BUF_WORDS(BW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .eng_busy(eng_busy), .eng_done(eng_done),
    .read_mode(read_mode), .op_req(op_req), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .suspend_req(suspend_req),
    .resume_req(resume_req), .suspended(suspended), .pin_mode(pin_mode),
    .err_erase(err_erase), .err_prog(err_prog), .err_seq(err_seq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input bit done = 0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; eng_done = done;
    @(negedge clk);
    wr_en = 1'b0; eng_done = 1'b0;
  endtask

  task automatic chk_req(input string tag, input int kind,
                         input logic [AW-1:0] a, input logic [7:0] d);
    chk({tag, " op_req"}, op_req, 1);
    chk({tag, " op_kind"}, op_kind, kind);
    chk({tag, " op_addr"}, op_addr, a);
    chk({tag, " op_data"}, op_data, d);
    chk({tag, " mode"}, read_mode, 3);
  endtask

  task automatic chk_err(input string tag, input bit e, input bit p, input bit s);
    chk({tag, " err_erase"}, err_erase, e);
    chk({tag, " err_prog"}, err_prog, p);
    chk({tag, " err_seq"}, err_seq, s);
  endtask

  function automatic bit is_cmd(input logic [7:0] c);
    return c inside {8'hFF, 8'h90, 8'h98, 8'h70, 8'h50, 8'h20, 8'h30, 8'h40,
                     8'h10, 8'hE8, 8'hB0, 8'hD0, 8'h60, 8'hB8};
  endfunction

  function automatic logic [1:0] mode_after(input logic [7:0] c, input logic [1:0] m);
    case (c)
      8'hFF: return 2'd0;
      8'h90: return 2'd1;
      8'h98: return 2'd2;
      8'h70: return 2'd3;
      default: return m;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] m;
    logic [7:0] c;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    eng_busy = 1'b0; eng_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 mode", read_mode, 0);
    chk_err("R1", 0, 0, 0);
    chk("R1 pin", pin_mode, 0);
    chk("R1 susp", suspended, 0);
    chk("R1 reqs", {op_req, suspend_req, resume_req}, 0);

    // R2 mode commands
    wr(0, 8'h90); chk("R2 ident", read_mode, 1);
    wr(0, 8'h98); chk("R2 query", read_mode, 2);
    wr(0, 8'h70); chk("R2 status", read_mode, 3);
    wr(0, 8'hFF); chk("R2 array", read_mode, 0);

    // R4 block and chip erase
    wr(22'h01000, 8'h20); chk("R4 setup noreq", op_req, 0);
    wr(22'h01234, 8'hD0); chk_req("R4 blk", 0, 22'h01234, 8'hD0);
    @(negedge clk); chk("R14 pulse", op_req, 0);
    wr(22'h3, 8'h30); wr(22'h77, 8'hD0); chk_req("R4 chip", 1, 22'h77, 8'hD0);

    // R5 program, both setup codes
    wr(0, 8'h40); wr(22'h2A5A5, 8'h5A); chk_req("R5 prog40", 2, 22'h2A5A5, 8'h5A);
    wr(0, 8'h10); wr(22'h00010, 8'hFF); chk_req("R5 prog10", 2, 22'h00010, 8'hFF);

    // R6 buffered write N=3
    wr(22'h00400, 8'hE8); wr(22'h00400, 8'h02);
    chk("R6 count noreq", op_req, 0);
    for (int i = 0; i < 3; i++) begin
      wr(22'h00400 + i, 8'hA0 + 8'(i));
      chk_req("R6 load", 3, 22'h00400 + i, 8'hA0 + 8'(i));
    end
    wr(22'h00400, 8'hD0); chk_req("R6 commit", 4, 22'h00400, 8'h02);
    // R6 N=1
    wr(22'h00900, 8'hE8); wr(0, 8'h00);
    wr(22'h00901, 8'h3C); chk_req("R6 N1 load", 3, 22'h00901, 8'h3C);
    wr(22'h00007, 8'hD0); chk_req("R6 N1 commit", 4, 22'h00900, 8'h00);
    // R6 count too large
    wr(0, 8'hFF);
    wr(0, 8'hE8); wr(0, 8'(BW));
    chk_err("R6 overflow", 0, 1, 1); chk("R6 overflow mode", read_mode, 3);
    wr(0, 8'h55); chk("R6 back idle", op_req, 0);
    // R3 clear
    wr(0, 8'h50); chk_err("R3 clear", 0, 0, 0);

    // R7 lock commands
    wr(22'h10000, 8'h60); wr(22'h10000, 8'h01); chk_req("R7 set", 5, 22'h10000, 8'h01);
    wr(0, 8'h60); wr(22'h5, 8'hD0); chk_req("R7 clr", 6, 22'h5, 8'hD0);

    // R8 pin mode values
    for (int v = 0; v < 4; v++) begin
      wr(0, 8'hB8); wr(0, 8'(v)); chk("R8 pin", pin_mode, v);
    end
    wr(0, 8'hB8); wr(0, 8'h01);

    // R9 bad confirms
    wr(0, 8'hFF);
    wr(0, 8'h20); wr(0, 8'h55);
    chk("R9 erase noreq", op_req, 0); chk_err("R9 erase", 1, 0, 1);
    chk("R9 erase mode", read_mode, 3);
    wr(0, 8'hFF); chk("R9 idle after", read_mode, 0);
    wr(0, 8'h50);
    wr(0, 8'hE8); wr(0, 8'h00); wr(1, 8'h11); wr(0, 8'h77);
    chk("R9 buf noreq", op_req, 0); chk_err("R9 buf", 0, 1, 1);
    wr(0, 8'h50);
    wr(0, 8'h60); wr(0, 8'h02); chk_err("R9 lock", 1, 1, 1);
    wr(0, 8'h50);
    wr(0, 8'hFF);
    wr(0, 8'hB8); wr(0, 8'h07); chk_err("R9 pin", 0, 0, 1);
    chk("R9 pin kept", pin_mode, 1); chk("R9 pin mode", read_mode, 3);
    wr(0, 8'h50); wr(0, 8'hFF);

    // R10 unknown codes and idle no-ops
    wr(0, 8'hA5); chk("R10 mode", read_mode, 0); chk("R10 req", op_req, 0);
    chk_err("R10", 0, 0, 0);
    wr(0, 8'hB0); chk("R10 suspend idle", {suspend_req, suspended}, 0);
    wr(0, 8'hD0); chk("R10 resume idle", {resume_req, read_mode}, 0);

    // R11 busy filter
    eng_busy = 1'b1;
    wr(0, 8'h70); chk("R11 status ok", read_mode, 3);
    wr(0, 8'hFF); chk("R11 array blocked", read_mode, 3);
    wr(0, 8'h20); wr(0, 8'hD0); chk("R11 erase blocked", op_req, 0);
    wr(0, 8'hB8); wr(0, 8'h02); chk("R11 pin ok", pin_mode, 2);

    // R12 suspend and resume
    wr(0, 8'hB0); chk("R12 sreq", suspend_req, 1); chk("R12 susp", suspended, 1);
    @(negedge clk); chk("R12 pulse", suspend_req, 0);
    wr(0, 8'hB0); chk("R12 no second", suspend_req, 0);
    eng_busy = 1'b0;
    wr(0, 8'hFF); chk("R12 array", read_mode, 0);
    wr(0, 8'hD0); chk("R12 rreq", resume_req, 1); chk("R12 cleared", suspended, 0);
    chk("R12 mode", read_mode, 3);

    // R13 done collides with resume
    eng_busy = 1'b1; wr(0, 8'hB0); eng_busy = 1'b0;
    wr(0, 8'hFF);
    wr(0, 8'hD0, 1); chk("R13 no rreq", resume_req, 0);
    chk("R13 cleared", suspended, 0); chk("R13 mode", read_mode, 3);
    eng_busy = 1'b1; wr(0, 8'hB0); eng_busy = 1'b0;
    @(negedge clk); eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
    chk("R13 done alone", suspended, 0);
    eng_busy = 1'b1; wr(0, 8'hB0, 1); eng_busy = 1'b0;
    chk("R13 susp vs done", {suspend_req, suspended}, 0);

    // R2 R10 random idle codes
    m = read_mode;
    for (int i = 0; i < 300; i++) begin
      case ($urandom % 5)
        0: c = 8'hFF;
        1: c = 8'h90;
        2: c = 8'h98;
        3: c = 8'h70;
        default: begin
          c = 8'($urandom);
          while (is_cmd(c)) c = 8'($urandom);
        end
      endcase
      wr(22'($urandom), c);
      m = mode_after(c, m);
      chk("R2/R10 random mode", read_mode, m);
      chk("R10 random noreq", {op_req, suspend_req, resume_req}, 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule